// File: doc/BRIEF.md
# GPU control register block

This block is the memory-mapped control register file of a graphics processor. A 32-bit write/read port reaches a command register, an interrupt register set and four groups of 64-bit power words covering four kinds of unit: shader cores, tiler, L2 and L3. Each 64-bit word is split into a low and a high 32-bit half. Reads are combinational on the address. Writes take effect on the rising clock edge when the write enable is high.

Power words are modelled rather than sequenced. A power-on write marks units ready at once, but only units that are present. A power-off write drops the ready bits directly. Every command completes in the cycle it is written. Some commands post a completion cause. Reset commands return the block to its reset state and also pulse a global reset request. Interrupt causes are held as sticky raw bits. Software clears them by writing ones. A mask selects the bits that drive the single interrupt line.

Top module: `gpu_ctrl_regs`

## Requirements
- R1: After reset, the present words read back the fixed configuration: shader low = 0xF, tiler low = 1, L2 low = 1, and every other present half = 0. All ready halves, raw status and mask read 0. `irq_o` and `gpu_reset_o` are low.
- R2: A write to a power-on half ORs (write data AND the matching present half) into the matching ready half.
- R3: A write to a power-off half clears the written bits in the matching ready half, whether or not those units are present.
- R4: Every power-on or power-off write sets raw status bit 0 (one unit changed) and bit 1 (all units changed) together.
- R5: Command codes 0 (no-op), 3 (counter clear), 5 (cycle count start) and 6 (cycle count stop) have no visible effect. Codes above 8 are ignored.
- R6: Command 1 (soft reset) and command 2 (hard reset) clear the ready words and the mask, and set raw status to exactly bit 2 (reset done). `gpu_reset_o` is high for exactly the one cycle after the command write.
- R7: Command 4 (counter sample) sets raw bit 3. Commands 7 (clean) and 8 (clean and invalidate) both set raw bit 4.
- R8: Writing ones to the clear word clears those raw bits. The mask word is read/write and holds the low 5 bits. The status word reads raw AND mask. `irq_o` is high exactly when that AND is nonzero.
- R9: Writes to the present words, the ready words, the raw status word, the status word and undecoded addresses change no state.
- R10: The byte address map is as follows. 0x00 is raw status, 0x04 is clear, 0x08 is mask, 0x0C is status and 0x10 is command. The present words start at 0x40, ready at 0x60, power-on at 0x80 and power-off at 0xA0. Within each group, a half sits at unit*8 + hi*4, with units in the order shader, tiler, L2, L3. The clear word, the command word and unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe, sampled on the rising edge |
| addr_i | input | 8 | Byte address, word aligned |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for addr_i |
| irq_o | output | 1 | Interrupt, high when masked status is nonzero |
| gpu_reset_o | output | 1 | One-cycle global reset request |

## Verification
Power-word writes and command writes reach their registers on the write edge. A wrong ready bit, raw bit or mask bit therefore shows on `rdata_o` as soon as the next read addresses it. When the masked status changes, `irq_o` shows the same fault in that same cycle. A reset command that misses a piece of state is exposed by the ready and mask reads right after the pulse on `gpu_reset_o`. A pulse that is missing or lasts more than one cycle is visible on the port.

// File: rtl/gpu_ctrl_pkg.sv
package gpu_ctrl_pkg;
  localparam int ADDR_W    = 8;
  localparam int DATA_W    = 32;
  localparam int NUM_UNITS = 4;
  localparam int UNIT_W    = $clog2(NUM_UNITS);
  localparam int IRQ_W     = 5;
  localparam int NUM_CMDS  = 9;

  localparam int IRQ_PWR_ONE     = 0;
  localparam int IRQ_PWR_ALL     = 1;
  localparam int IRQ_RST_DONE    = 2;
  localparam int IRQ_SAMPLE_DONE = 3;
  localparam int IRQ_CLEAN_DONE  = 4;

  typedef enum logic [3:0] {
    CMD_NOP       = 4'd0,
    CMD_SOFT_RST  = 4'd1,
    CMD_HARD_RST  = 4'd2,
    CMD_PC_CLEAR  = 4'd3,
    CMD_PC_SAMPLE = 4'd4,
    CMD_CC_START  = 4'd5,
    CMD_CC_STOP   = 4'd6,
    CMD_CLEAN     = 4'd7,
    CMD_CLEAN_INV = 4'd8
  } cmd_e;

  typedef enum logic [2:0] {
    GRP_CTRL    = 3'd0,
    GRP_PRESENT = 3'd2,
    GRP_READY   = 3'd3,
    GRP_PWRON   = 3'd4,
    GRP_PWROFF  = 3'd5
  } grp_e;

  typedef struct packed {
    logic clr_we;
    logic mask_we;
    logic cmd_we;
    logic on_we;
    logic off_we;
  } wr_dec_t;
endpackage

// File: rtl/gpu_ctrl_decode.sv
module gpu_ctrl_decode
  import gpu_ctrl_pkg::*;
(
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output wr_dec_t           dec_o,
  output logic [UNIT_W-1:0] unit_o,
  output logic              hi_o
);
  logic aligned;
  assign aligned = (addr_i[1:0] == 2'b00);
  assign unit_o  = addr_i[4:3];
  assign hi_o    = addr_i[2];

  always_comb begin
    dec_o = '0;
    if (wr_en_i && aligned) begin
      case (addr_i[7:5])
        GRP_CTRL: begin
          case (addr_i[4:2])
            3'd1:    dec_o.clr_we  = 1'b1;
            3'd2:    dec_o.mask_we = 1'b1;
            3'd4:    dec_o.cmd_we  = 1'b1;
            default: ;
          endcase
        end
        GRP_PWRON:  dec_o.on_we  = 1'b1;
        GRP_PWROFF: dec_o.off_we = 1'b1;
        default: ;
      endcase
    end
  end

  // at most one write target per access
  always_comb begin
    if (wr_en_i) assert_one_target_R10: assert ($onehot0(dec_o));
  end
endmodule

// File: rtl/gpu_ctrl_cmd.sv
module gpu_ctrl_cmd
  import gpu_ctrl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [IRQ_W-1:0]  cause_o,
  output logic              soft_rst_o,
  output logic              gpu_reset_o
);
  logic in_range;
  cmd_e code;
  assign in_range = (wdata_i < DATA_W'(NUM_CMDS));
  assign code     = cmd_e'(wdata_i[3:0]);

  always_comb begin
    cause_o    = '0;
    soft_rst_o = 1'b0;
    if (cmd_we_i && in_range) begin
      case (code)
        CMD_SOFT_RST, CMD_HARD_RST: begin
          soft_rst_o            = 1'b1;
          cause_o[IRQ_RST_DONE] = 1'b1;
        end
        CMD_PC_SAMPLE:            cause_o[IRQ_SAMPLE_DONE] = 1'b1;
        CMD_CLEAN, CMD_CLEAN_INV: cause_o[IRQ_CLEAN_DONE]  = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gpu_reset_o <= 1'b0;
    else         gpu_reset_o <= soft_rst_o;
  end

  assert_bad_code_ignored_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && (wdata_i >= DATA_W'(NUM_CMDS))) |-> (cause_o == '0 && !soft_rst_o));

  assert_reset_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |=> gpu_reset_o);
endmodule

// File: rtl/gpu_ctrl_irq.sv
module gpu_ctrl_irq
  import gpu_ctrl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             soft_rst_i,
  input  logic [IRQ_W-1:0] set_i,
  input  logic             clr_we_i,
  input  logic             mask_we_i,
  input  logic [IRQ_W-1:0] wdata_i,
  output logic [IRQ_W-1:0] raw_o,
  output logic [IRQ_W-1:0] mask_o,
  output logic             irq_o
);
  logic [IRQ_W-1:0] raw_q, mask_q, clr_bits;
  assign clr_bits = clr_we_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else if (soft_rst_i) begin
      raw_q  <= set_i;
      mask_q <= '0;
    end else begin
      raw_q <= (raw_q & ~clr_bits) | set_i;
      if (mask_we_i) mask_q <= wdata_i;
    end
  end

  assign raw_o  = raw_q;
  assign mask_o = mask_q;
  assign irq_o  = |(raw_q & mask_q);

  assert_clear_w1c_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && set_i == '0 && !soft_rst_i) |=> ((raw_q & $past(wdata_i)) == '0));

  assert_mask_cleared_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (mask_q == '0 && !irq_o));
endmodule

// File: rtl/gpu_ctrl_pwr.sv
module gpu_ctrl_pwr
  import gpu_ctrl_pkg::*;
#(
  parameter logic [NUM_UNITS-1:0][63:0] PRESENT_CFG = {64'h0, 64'h1, 64'h1, 64'hF}
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         soft_rst_i,
  input  logic                         on_we_i,
  input  logic                         off_we_i,
  input  logic [UNIT_W-1:0]            unit_i,
  input  logic                         hi_i,
  input  logic [DATA_W-1:0]            wdata_i,
  output logic [NUM_UNITS-1:0][63:0]   ready_o
);
  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    for (genvar h = 0; h < 2; h++) begin : g_half
      logic [31:0] ready_q;
      logic        hit;
      localparam logic [31:0] PRES = PRESENT_CFG[u][h*32 +: 32];
      assign hit = (unit_i == UNIT_W'(u)) && (hi_i == h[0]);

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                 ready_q <= '0;
        else if (soft_rst_i)         ready_q <= '0;
        else if (on_we_i && hit)     ready_q <= ready_q | (wdata_i & PRES);
        else if (off_we_i && hit)    ready_q <= ready_q & ~wdata_i;
      end

      assign ready_o[u][h*32 +: 32] = ready_q;

      assert_ready_in_present_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ready_q & ~PRES) == '0);

      assert_off_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (off_we_i && hit && !soft_rst_i) |=> ((ready_q & $past(wdata_i)) == '0));
    end
  end
endmodule

// File: rtl/gpu_ctrl_regs.sv
module gpu_ctrl_regs
  import gpu_ctrl_pkg::*;
#(
  parameter logic [NUM_UNITS-1:0][63:0] PRESENT_CFG = {64'h0, 64'h1, 64'h1, 64'hF}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              gpu_reset_o
);
  wr_dec_t                      dec;
  logic [UNIT_W-1:0]            unit;
  logic                         hi;
  logic [IRQ_W-1:0]             cmd_cause, pwr_cause, set_bits, raw, mask;
  logic                         soft_rst;
  logic [NUM_UNITS-1:0][63:0]   ready;

  gpu_ctrl_decode u_decode (
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .dec_o   (dec),
    .unit_o  (unit),
    .hi_o    (hi)
  );

  gpu_ctrl_cmd u_cmd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_we_i    (dec.cmd_we),
    .wdata_i     (wdata_i),
    .cause_o     (cmd_cause),
    .soft_rst_o  (soft_rst),
    .gpu_reset_o (gpu_reset_o)
  );

  gpu_ctrl_pwr #(.PRESENT_CFG(PRESENT_CFG)) u_pwr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_rst_i (soft_rst),
    .on_we_i    (dec.on_we),
    .off_we_i   (dec.off_we),
    .unit_i     (unit),
    .hi_i       (hi),
    .wdata_i    (wdata_i),
    .ready_o    (ready)
  );

  always_comb begin
    pwr_cause = '0;
    if (dec.on_we || dec.off_we) begin
      pwr_cause[IRQ_PWR_ONE] = 1'b1;
      pwr_cause[IRQ_PWR_ALL] = 1'b1;
    end
  end
  assign set_bits = cmd_cause | pwr_cause;

  gpu_ctrl_irq u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_rst_i (soft_rst),
    .set_i      (set_bits),
    .clr_we_i   (dec.clr_we),
    .mask_we_i  (dec.mask_we),
    .wdata_i    (wdata_i[IRQ_W-1:0]),
    .raw_o      (raw),
    .mask_o     (mask),
    .irq_o      (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    if (addr_i[1:0] == 2'b00) begin
      case (addr_i[7:5])
        GRP_CTRL: begin
          case (addr_i[4:2])
            3'd0:    rdata_o = DATA_W'(raw);
            3'd2:    rdata_o = DATA_W'(mask);
            3'd3:    rdata_o = DATA_W'(raw & mask);
            default: rdata_o = '0;
          endcase
        end
        GRP_PRESENT: rdata_o = hi ? PRESENT_CFG[unit][63:32] : PRESENT_CFG[unit][31:0];
        GRP_READY:   rdata_o = hi ? ready[unit][63:32] : ready[unit][31:0];
        default:     rdata_o = '0;
      endcase
    end
  end

  assert_pwr_causes_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec.on_we || dec.off_we) |=> (raw[IRQ_PWR_ONE] && raw[IRQ_PWR_ALL]));

  assert_reset_state_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst |=> (raw == IRQ_W'(1 << IRQ_RST_DONE) && ready == '0));

  assert_sample_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec.cmd_we && wdata_i == DATA_W'(CMD_PC_SAMPLE)) |=> raw[IRQ_SAMPLE_DONE]);
endmodule

// File: tb/gpu_ctrl_regs_tb.sv
module gpu_ctrl_regs_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  typedef struct packed {
    logic        wr;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 58;
  localparam vec_t VECS [0:NV-1] = '{
    '{1'b0, 8'h40, 32'h0, 32'hF, 8'd1},          // R1 present shader lo
    '{1'b0, 8'h44, 32'h0, 32'h0, 8'd1},
    '{1'b0, 8'h48, 32'h0, 32'h1, 8'd1},
    '{1'b0, 8'h50, 32'h0, 32'h1, 8'd1},
    '{1'b0, 8'h58, 32'h0, 32'h0, 8'd1},
    '{1'b0, 8'h60, 32'h0, 32'h0, 8'd1},          // R1 ready zero
    '{1'b0, 8'h00, 32'h0, 32'h0, 8'd1},
    '{1'b0, 8'h08, 32'h0, 32'h0, 8'd1},
    '{1'b1, 8'h80, 32'hFF, 32'h0, 8'd2},         // R2 power-on shader lo
    '{1'b0, 8'h60, 32'h0, 32'hF, 8'd2},
    '{1'b0, 8'h00, 32'h0, 32'h3, 8'd4},          // R4 both power causes
    '{1'b1, 8'h04, 32'h3, 32'h0, 8'd8},
    '{1'b0, 8'h00, 32'h0, 32'h0, 8'd8},
    '{1'b1, 8'h84, 32'hFFFF_FFFF, 32'h0, 8'd2},  // R2 hi half not present
    '{1'b0, 8'h64, 32'h0, 32'h0, 8'd2},
    '{1'b0, 8'h00, 32'h0, 32'h3, 8'd4},
    '{1'b1, 8'hA0, 32'h5, 32'h0, 8'd3},          // R3 power-off
    '{1'b0, 8'h60, 32'h0, 32'hA, 8'd3},
    '{1'b1, 8'h88, 32'h3, 32'h0, 8'd2},          // R2 tiler
    '{1'b0, 8'h68, 32'h0, 32'h1, 8'd2},
    '{1'b1, 8'h04, 32'h1F, 32'h0, 8'd8},
    '{1'b1, 8'hB8, 32'hFFFF_FFFF, 32'h0, 8'd3},  // R3 L3 absent, still accepted
    '{1'b0, 8'h78, 32'h0, 32'h0, 8'd3},
    '{1'b0, 8'h00, 32'h0, 32'h3, 8'd4},
    '{1'b1, 8'h40, 32'h0, 32'h0, 8'd9},          // R9 present write ignored
    '{1'b0, 8'h40, 32'h0, 32'hF, 8'd9},
    '{1'b1, 8'h60, 32'h0, 32'h0, 8'd9},          // R9 ready write ignored
    '{1'b0, 8'h60, 32'h0, 32'hA, 8'd9},
    '{1'b1, 8'h04, 32'h1F, 32'h0, 8'd8},
    '{1'b1, 8'h00, 32'h1F, 32'h0, 8'd9},         // R9 raw write ignored
    '{1'b0, 8'h00, 32'h0, 32'h0, 8'd9},
    '{1'b1, 8'h0C, 32'h1F, 32'h0, 8'd9},
    '{1'b0, 8'h08, 32'h0, 32'h0, 8'd9},
    '{1'b1, 8'hF0, 32'hFFFF_FFFF, 32'h0, 8'd9},
    '{1'b0, 8'h60, 32'h0, 32'hA, 8'd9},
    '{1'b0, 8'h04, 32'h0, 32'h0, 8'd10},         // R10 clear word reads 0
    '{1'b0, 8'hFC, 32'h0, 32'h0, 8'd10},
    '{1'b1, 8'h10, 32'h4, 32'h0, 8'd7},          // R7 sample
    '{1'b0, 8'h00, 32'h0, 32'h8, 8'd7},
    '{1'b1, 8'h10, 32'h7, 32'h0, 8'd7},          // R7 clean
    '{1'b0, 8'h00, 32'h0, 32'h18, 8'd7},
    '{1'b1, 8'h04, 32'h1F, 32'h0, 8'd8},
    '{1'b1, 8'h10, 32'h8, 32'h0, 8'd7},          // R7 clean+inv same cause
    '{1'b0, 8'h00, 32'h0, 32'h10, 8'd7},
    '{1'b1, 8'h04, 32'h1F, 32'h0, 8'd8},
    '{1'b1, 8'h10, 32'h0, 32'h0, 8'd5},          // R5 silent commands
    '{1'b1, 8'h10, 32'h3, 32'h0, 8'd5},
    '{1'b1, 8'h10, 32'h5, 32'h0, 8'd5},
    '{1'b1, 8'h10, 32'h6, 32'h0, 8'd5},
    '{1'b1, 8'h10, 32'h9, 32'h0, 8'd5},
    '{1'b1, 8'h10, 32'hFFFF_FFFF, 32'h0, 8'd5},
    '{1'b0, 8'h00, 32'h0, 32'h0, 8'd5},
    '{1'b0, 8'h60, 32'h0, 32'hA, 8'd5},
    '{1'b1, 8'h08, 32'hFFFF_FFFF, 32'h0, 8'd8},  // R8 mask holds 5 bits
    '{1'b0, 8'h08, 32'h0, 32'h1F, 8'd8},
    '{1'b1, 8'h10, 32'h7, 32'h0, 8'd8},
    '{1'b0, 8'h0C, 32'h0, 32'h10, 8'd8},
    '{1'b1, 8'h08, 32'h8, 32'h0, 8'd8}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;
  logic        gpu_reset_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  gpu_ctrl_regs u_dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .rdata_o     (rdata_o),
    .irq_o       (irq_o),
    .gpu_reset_o (gpu_reset_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0; wdata_i = '0;
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
    addr_i = a;
    #1;
    check(req, rdata_o, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 irq", {31'b0, irq_o}, 32'h0);
    check("R1 gpu_reset", {31'b0, gpu_reset_o}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) wr(VECS[i].addr, VECS[i].data);
      else rd($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].addr, VECS[i].exp);
    end

    // R8: raw=0x10, mask=0x08 here
    check("R8 irq masked", {31'b0, irq_o}, 32'h0);
    wr(8'h08, 32'h10);
    check("R8 irq set", {31'b0, irq_o}, 32'h1);
    wr(8'h04, 32'h10);
    check("R8 irq cleared", {31'b0, irq_o}, 32'h0);

    // R6 soft reset
    wr(8'h08, 32'h1F);
    wr(8'h80, 32'h3);
    check("R8 irq power", {31'b0, irq_o}, 32'h1);
    wr(8'h10, 32'h1);
    check("R6 soft pulse", {31'b0, gpu_reset_o}, 32'h1);
    check("R6 soft irq", {31'b0, irq_o}, 32'h0);
    rd("R6 soft raw", 8'h00, 32'h4);
    rd("R6 soft mask", 8'h08, 32'h0);
    rd("R6 soft ready shader", 8'h60, 32'h0);
    rd("R6 soft ready tiler", 8'h68, 32'h0);
    @(negedge clk_i);
    check("R6 soft pulse end", {31'b0, gpu_reset_o}, 32'h0);

    // R6 hard reset
    wr(8'h08, 32'h1F);
    wr(8'h90, 32'h1);
    rd("R2 L2 on", 8'h70, 32'h1);
    wr(8'h10, 32'h2);
    check("R6 hard pulse", {31'b0, gpu_reset_o}, 32'h1);
    rd("R6 hard raw", 8'h00, 32'h4);
    rd("R6 hard mask", 8'h08, 32'h0);
    rd("R6 hard ready L2", 8'h70, 32'h0);
    @(negedge clk_i);
    check("R6 hard pulse end", {31'b0, gpu_reset_o}, 32'h0);
    rd("R1 present after reset", 8'h40, 32'hF);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule